// File: doc/BRIEF.md
# Serial Audio Link Frame Transmitter with Power-Up Register Programming

This block drives the outbound half of a serial audio codec link. It runs on the bit clock that the codec supplies. It sends one 256-bit frame after another, with no gap between them. Each frame starts with a 16-bit tag slot and is followed by twelve 20-bit slots. A frame-sync strobe marks the tag slot of every frame. Bits go out MSB first and change on the rising clock edge, so the codec can sample them on the falling edge.

After reset the block sends empty frames until the codec reports ready. It then writes a fixed list of control registers, one write per frame. The list sets variable-rate mode, sets the DAC sample rate to 0x0FA0, and sets the master and PCM-out volume/mute registers. Once the list is finished, stereo PCM sample pairs are taken from a valid/ready input. Volume or mute changes are taken from a second valid/ready input and sent as register writes.

Both input streams follow valid/ready rules. A transfer happens on a rising edge where valid and ready are both high. The sample stream gives back-pressure by keeping `pcm_ready` low except in the last bit period of each frame, and only once programming is done. This means at most one pair is taken per frame. The source may change its data freely while ready is low. The volume stream has a one-entry queue, and `vol_ready` is low while that entry is occupied or while programming is still running.

Top module: `ac97_link_tx`

## Requirements
- R1: Every frame lasts 256 bit clocks and is sent MSB first. It holds a 16-bit tag slot (slot 0) followed by slots 1 to 12 of 20 bits each. Frames follow one another back to back, starting at reset release.
- R2: `sync` is high for exactly the 16 bit periods of slot 0 in every frame and is low for the rest of the frame.
- R3: The tag slot bits are as follows. Bit 15 is set when any slot is valid. Bits 14 and 13 flag the command slots 1 and 2. Bits 12 and 11 flag the PCM slots 3 and 4. Bits 10 to 0, which include the two-bit codec ID, are sent as zero.
- R4: A register write sets slot 1 bit 19 to 0 (write) and carries the 7-bit register index in bits 18:12, with bits 11:0 zero. Slot 2 carries the 16-bit value in bits 19:4, with bits 3:0 zero.
- R5: No command is sent until `codec_ready` is high at a frame boundary, which is the rising edge that ends a frame. A frame without a command has tag bits 14 and 13 clear and slots 1 and 2 zero.
- R6: Each boundary at which `codec_ready` is high sends the next programming write, and boundaries with it low are skipped. The writes go in this order: index 0x2A with 0x0001, index 0x2C with 0x0FA0, index 0x02 with INIT_MASTER_VOL (default 0x0404), then index 0x18 with INIT_PCM_VOL (default 0x0808). `init_done` rises at the boundary that sends the last write.
- R7: `pcm_ready` is high only in the last bit period of a frame and only while `init_done` is high. A pair taken at a boundary appears in slots 3 (left) and 4 (right) of the frame that starts there.
- R8: If no pair is taken at a boundary, the next frame has tag bits 12 and 11 clear and slots 3 and 4 zero.
- R9: Slots 5 to 12 are always zero.
- R10: `vol_ready` is high only when `init_done` is high and the one-entry queue is empty. A queued write is kept until the next boundary and is sent in the frame that starts there, encoded as in R4.
- R11: While reset is held, `sync` is high, `sdata_out` is 0, and `pcm_ready`, `vol_ready` and `init_done` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Bit clock supplied by the codec |
| rst | input | 1 | Synchronous reset, active high |
| codec_ready | input | 1 | Codec reports it accepts commands |
| pcm_valid | input | 1 | A stereo sample pair is offered |
| pcm_ready | output | 1 | Pair is taken on this edge if valid |
| pcm_left | input | 20 | Left sample |
| pcm_right | input | 20 | Right sample |
| vol_valid | input | 1 | A volume/mute register write is offered |
| vol_ready | output | 1 | Queue can take the write |
| vol_index | input | 7 | Register index of the volume write |
| vol_value | input | 16 | Value of the volume write |
| sync | output | 1 | Frame sync, high during slot 0 |
| sdata_out | output | 1 | Serial frame data toward the codec |
| init_done | output | 1 | Programming list has been sent |

## Verification
The hardest case to reach is a volume request that arrives while an earlier one is still queued. This has to happen right after programming has finished, while sample pairs are still flowing. The stimulus holds `codec_ready` low for several boundaries and drops it again once in the middle of programming. It then offers a first volume write, and in a later frame a second write followed quickly by a third. The third must stay blocked until the boundary that sends the second, and it must come out in the frame after that. Every frame is rebuilt bit by bit from `sync` and `sdata_out` and compared with a frame computed from the schedule. This catches a command sent early, a missed or reordered programming step, and a sample pair taken in the wrong frame.

// File: rtl/ac97_tx_pkg.sv
package ac97_tx_pkg;
  localparam int TAG_BITS   = 16;
  localparam int SLOT_BITS  = 20;
  localparam int SLOT_COUNT = 13;

  localparam logic [6:0]  IDX_EXT_CTRL = 7'h2A;
  localparam logic [6:0]  IDX_DAC_RATE = 7'h2C;
  localparam logic [6:0]  IDX_MASTER   = 7'h02;
  localparam logic [6:0]  IDX_PCM_OUT  = 7'h18;
  localparam logic [15:0] VAL_VRA_ON   = 16'h0001;
  localparam logic [15:0] VAL_RATE     = 16'h0FA0;

  typedef struct packed {
    logic [6:0]  idx;
    logic [15:0] val;
  } reg_wr_t;

  function automatic logic [SLOT_BITS-1:0] addr_word(input logic [6:0] idx);
    return {1'b0, idx, 12'b0};
  endfunction

  function automatic logic [SLOT_BITS-1:0] data_word(input logic [15:0] val);
    return {val, 4'b0};
  endfunction
endpackage

// File: rtl/ac97_slot_timer.sv
module ac97_slot_timer #(
  parameter int TAG_BITS   = 16,
  parameter int SLOT_BITS  = 20,
  parameter int SLOT_COUNT = 13,
  localparam int SW = $clog2(SLOT_COUNT),
  localparam int BW = $clog2(SLOT_BITS)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [SW-1:0] slot_idx,
  output logic [BW-1:0] bit_idx,
  output logic          frame_end,
  output logic          sync
);
  localparam int FRAME_LEN = TAG_BITS + (SLOT_COUNT - 1) * SLOT_BITS;
  localparam int FW = $clog2(FRAME_LEN);
  localparam int RW = $clog2(TAG_BITS + 1);

  logic last_slot;
  assign last_slot = (slot_idx == SW'(SLOT_COUNT - 1));
  assign frame_end = last_slot && (bit_idx == '0);
  assign sync      = (slot_idx == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_idx <= '0;
      bit_idx  <= BW'(TAG_BITS - 1);
    end else if (bit_idx == '0) begin
      if (last_slot) begin
        slot_idx <= '0;
        bit_idx  <= BW'(TAG_BITS - 1);
      end else begin
        slot_idx <= slot_idx + 1'b1;
        bit_idx  <= BW'(SLOT_BITS - 1);
      end
    end else begin
      bit_idx <= bit_idx - 1'b1;
    end
  end

  // independent position and sync-run counters for the checks below
  logic [FW-1:0] pos_q;
  logic [RW-1:0] run_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
      run_q <= '0;
    end else begin
      pos_q <= (pos_q == FW'(FRAME_LEN - 1)) ? '0 : pos_q + 1'b1;
      run_q <= sync ? run_q + 1'b1 : '0;
    end
  end

  p_frame_len_r1: assert property (@(posedge clk) disable iff (rst)
    frame_end |-> (pos_q == FW'(FRAME_LEN - 1)));
  p_sync_len_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(sync) |-> (run_q == RW'(TAG_BITS)));
endmodule

// File: rtl/ac97_cmd_seq.sv
module ac97_cmd_seq
  import ac97_tx_pkg::*;
#(
  parameter logic [15:0] INIT_MASTER_VOL = 16'h0404,
  parameter logic [15:0] INIT_PCM_VOL    = 16'h0808
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       frame_end,
  input  logic       codec_ready,
  input  logic       vol_valid,
  output logic       vol_ready,
  input  logic [6:0] vol_index,
  input  logic [15:0] vol_value,
  output logic       cmd_fire,
  output reg_wr_t    cmd,
  output logic       init_done
);
  localparam int STEPS  = 4;
  localparam int STEP_W = $clog2(STEPS);

  logic [STEP_W-1:0] step_q;
  reg_wr_t           init_entry;
  reg_wr_t           hold_q;
  logic              hold_v;

  always_comb begin
    case (step_q)
      STEP_W'(0): init_entry = '{idx: IDX_EXT_CTRL, val: VAL_VRA_ON};
      STEP_W'(1): init_entry = '{idx: IDX_DAC_RATE, val: VAL_RATE};
      STEP_W'(2): init_entry = '{idx: IDX_MASTER,   val: INIT_MASTER_VOL};
      default:    init_entry = '{idx: IDX_PCM_OUT,  val: INIT_PCM_VOL};
    endcase
  end

  assign vol_ready = init_done && !hold_v;
  assign cmd_fire  = frame_end && (init_done ? hold_v : codec_ready);
  assign cmd       = init_done ? hold_q : init_entry;

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q    <= '0;
      init_done <= 1'b0;
      hold_v    <= 1'b0;
      hold_q    <= '0;
    end else begin
      if (frame_end && !init_done && codec_ready) begin
        step_q <= step_q + 1'b1;
        if (step_q == STEP_W'(STEPS - 1)) init_done <= 1'b1;
      end
      if (frame_end && init_done && hold_v) hold_v <= 1'b0;
      if (vol_valid && vol_ready) begin
        hold_v <= 1'b1;
        hold_q <= '{idx: vol_index, val: vol_value};
      end
    end
  end

  p_queue_kept_r10: assert property (@(posedge clk) disable iff (rst)
    (hold_v && !frame_end) |=> (hold_v && $stable(hold_q)));
  p_done_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);
endmodule

// File: rtl/ac97_frame_builder.sv
module ac97_frame_builder
  import ac97_tx_pkg::*;
#(
  parameter int TAG_BITS   = 16,
  parameter int SLOT_BITS  = 20,
  parameter int SLOT_COUNT = 13,
  localparam int SW = $clog2(SLOT_COUNT),
  localparam int BW = $clog2(SLOT_BITS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 frame_end,
  input  logic                 cmd_fire,
  input  reg_wr_t              cmd,
  input  logic                 pcm_take,
  input  logic [SLOT_BITS-1:0] pcm_left,
  input  logic [SLOT_BITS-1:0] pcm_right,
  input  logic [SW-1:0]        slot_idx,
  input  logic [BW-1:0]        bit_idx,
  output logic                 cmd_live,
  output logic                 sdata
);
  logic                 pcm_live;
  logic [SLOT_BITS-1:0] s1_q, s2_q, left_q, right_q;
  logic [TAG_BITS-1:0]  tag;
  logic [SLOT_BITS-1:0] word;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_live <= 1'b0;
      pcm_live <= 1'b0;
      s1_q     <= '0;
      s2_q     <= '0;
      left_q   <= '0;
      right_q  <= '0;
    end else if (frame_end) begin
      cmd_live <= cmd_fire;
      pcm_live <= pcm_take;
      s1_q     <= cmd_fire ? addr_word(cmd.idx) : '0;
      s2_q     <= cmd_fire ? data_word(cmd.val) : '0;
      left_q   <= pcm_take ? pcm_left  : '0;
      right_q  <= pcm_take ? pcm_right : '0;
    end
  end

  assign tag = {cmd_live | pcm_live, cmd_live, cmd_live, pcm_live, pcm_live,
                {(TAG_BITS - 5){1'b0}}};

  always_comb begin
    case (slot_idx)
      SW'(0):  word = SLOT_BITS'(tag);
      SW'(1):  word = s1_q;
      SW'(2):  word = s2_q;
      SW'(3):  word = left_q;
      SW'(4):  word = right_q;
      default: word = '0;
    endcase
  end
  assign sdata = word[bit_idx];

  p_pcm_steady_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(frame_end) |-> ($stable(left_q) && $stable(right_q)));
  p_idle_cmd_zero_r5: assert property (@(posedge clk) disable iff (rst)
    !cmd_live |-> (s1_q == '0 && s2_q == '0));
endmodule

// File: rtl/ac97_link_tx.sv
module ac97_link_tx
  import ac97_tx_pkg::*;
#(
  parameter logic [15:0] INIT_MASTER_VOL = 16'h0404,
  parameter logic [15:0] INIT_PCM_VOL    = 16'h0808
) (
  input  logic        bit_clk,
  input  logic        rst,
  input  logic        codec_ready,
  input  logic        pcm_valid,
  output logic        pcm_ready,
  input  logic [19:0] pcm_left,
  input  logic [19:0] pcm_right,
  input  logic        vol_valid,
  output logic        vol_ready,
  input  logic [6:0]  vol_index,
  input  logic [15:0] vol_value,
  output logic        sync,
  output logic        sdata_out,
  output logic        init_done
);
  localparam int SW = $clog2(SLOT_COUNT);
  localparam int BW = $clog2(SLOT_BITS);

  logic [SW-1:0] slot_idx;
  logic [BW-1:0] bit_idx;
  logic          frame_end, cmd_fire, cmd_live, pcm_take;
  reg_wr_t       cmd;

  ac97_slot_timer #(.TAG_BITS(TAG_BITS), .SLOT_BITS(SLOT_BITS), .SLOT_COUNT(SLOT_COUNT)) u_timer (
    .clk(bit_clk), .rst(rst), .slot_idx(slot_idx), .bit_idx(bit_idx),
    .frame_end(frame_end), .sync(sync));

  ac97_cmd_seq #(.INIT_MASTER_VOL(INIT_MASTER_VOL), .INIT_PCM_VOL(INIT_PCM_VOL)) u_seq (
    .clk(bit_clk), .rst(rst), .frame_end(frame_end), .codec_ready(codec_ready),
    .vol_valid(vol_valid), .vol_ready(vol_ready), .vol_index(vol_index),
    .vol_value(vol_value), .cmd_fire(cmd_fire), .cmd(cmd), .init_done(init_done));

  assign pcm_ready = frame_end && init_done;
  assign pcm_take  = pcm_ready && pcm_valid;

  ac97_frame_builder #(.TAG_BITS(TAG_BITS), .SLOT_BITS(SLOT_BITS), .SLOT_COUNT(SLOT_COUNT)) u_build (
    .clk(bit_clk), .rst(rst), .frame_end(frame_end), .cmd_fire(cmd_fire), .cmd(cmd),
    .pcm_take(pcm_take), .pcm_left(pcm_left), .pcm_right(pcm_right),
    .slot_idx(slot_idx), .bit_idx(bit_idx), .cmd_live(cmd_live), .sdata(sdata_out));

  logic seen_ready;
  always_ff @(posedge bit_clk) begin
    if (rst) seen_ready <= 1'b0;
    else     seen_ready <= seen_ready | codec_ready;
  end

  p_ready_first_r5: assert property (@(posedge bit_clk) disable iff (rst)
    cmd_live |-> seen_ready);
  p_quiet_tail_r9: assert property (@(posedge bit_clk) disable iff (rst)
    (slot_idx > SW'(4)) |-> !sdata_out);
  p_sync_slot0_r2: assert property (@(posedge bit_clk) disable iff (rst)
    $rose(sync) |-> $past(frame_end));
endmodule

// File: tb/ac97_link_tx_test.sv
module ac97_link_tx_test;
  localparam int CLK_PERIOD = 10;
  localparam int NFRAMES    = 14;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic        rst = 1'b1, codec_ready = 1'b0, pcm_valid = 1'b0, vol_valid = 1'b0;
  logic [19:0] pcm_left = '0, pcm_right = '0;
  logic [6:0]  vol_index = '0;
  logic [15:0] vol_value = '0;
  logic        pcm_ready, vol_ready, sync, sdata_out, init_done;

  ac97_link_tx uut (
    .bit_clk(clk), .rst(rst), .codec_ready(codec_ready), .pcm_valid(pcm_valid),
    .pcm_ready(pcm_ready), .pcm_left(pcm_left), .pcm_right(pcm_right),
    .vol_valid(vol_valid), .vol_ready(vol_ready), .vol_index(vol_index),
    .vol_value(vol_value), .sync(sync), .sdata_out(sdata_out), .init_done(init_done));

  int checks = 0, fails = 0;
  logic [255:0] exp_q[$];
  string        lbl_q[$];

  task automatic check(input bit ok, input string req, input logic [255:0] got, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  // reference model state
  int          step = 0;
  bit          done = 0, qv = 0;
  logic [6:0]  qi;
  logic [15:0] qd;

  function automatic logic [22:0] init_entry(input int s);
    case (s)
      0: return {7'h2A, 16'h0001};
      1: return {7'h2C, 16'h0FA0};
      2: return {7'h02, 16'h0404};
      default: return {7'h18, 16'h0808};
    endcase
  endfunction

  function automatic logic [255:0] mk(input bit cv, input logic [6:0] i, input logic [15:0] d,
                                      input bit pv, input logic [19:0] l, input logic [19:0] r);
    logic [15:0] tag;
    tag = {cv | pv, cv, cv, pv, pv, 11'b0};
    return {tag, cv ? {1'b0, i, 12'b0} : 20'h0, cv ? {d, 4'b0} : 20'h0,
            pv ? l : 20'h0, pv ? r : 20'h0, 160'b0};
  endfunction

  // frame boundary decision, applied at the last bit of a frame
  task automatic boundary();
    bit cv = 0, pv, nd;
    logic [6:0] i = '0;
    logic [15:0] d = '0;
    nd = done;
    if (!done) begin
      if (codec_ready) begin
        cv = 1;
        {i, d} = init_entry(step);
        step++;
        if (step == 4) nd = 1;
      end
    end else if (qv) begin
      cv = 1; i = qi; d = qd; qv = 0;
    end
    pv = done && pcm_valid;
    exp_q.push_back(mk(cv, i, d, pv, pcm_left, pcm_right));
    lbl_q.push_back($sformatf("R1 R3 R9%s%s%s", cv ? " R4 R6 R10" : "",
                    (!cv && !done) ? " R5" : "", pv ? " R7" : " R8"));
    done = nd;
  endtask

  task automatic schedule(input int f);
    codec_ready = !(f < 2 || f == 3);
    pcm_valid   = !(f == 8 || f == 12);
    case (f)
      7:  begin pcm_left = 20'hABCDE; pcm_right = 20'h12345; end
      9:  begin pcm_left = 20'h00001; pcm_right = 20'h80000; end
      10: begin pcm_left = 20'hFFFFF; pcm_right = 20'hFFFFF; end
      11: begin pcm_left = 20'h5A5A5; pcm_right = 20'hA5A5A; end
      default: begin pcm_left = 20'h11111 * 20'(f + 1); pcm_right = 20'h22222; end
    endcase
  endtask

  task automatic offer_vol(input logic [6:0] i, input logic [15:0] d);
    vol_valid = 1'b1; vol_index = i; vol_value = d;
  endtask

  task automatic driver();
    exp_q.push_back(mk(0, '0, '0, 0, '0, '0));
    lbl_q.push_back("R1 R3 R5 R11");
    for (int f = 0; f < NFRAMES; f++) begin
      for (int c = 0; c < 256; c++) begin
        if (f > 0 || c > 0) @(negedge clk);
        if (vol_valid && c == 1) vol_valid = 1'b0;
        if (f == 4 && c == 100) check(vol_ready == 1'b0, "R10 ready during programming", 256'(vol_ready), 0);
        if (f == 6 && c == 100) check(init_done == 1'b0, "R6 init_done early", 256'(init_done), 0);
        if (f == 7 && c == 0)   check(init_done == 1'b1, "R6 init_done after last write", 256'(init_done), 1);
        if (f == 1 && c == 255) check(pcm_ready == 1'b0, "R7 pcm_ready before init", 256'(pcm_ready), 0);
        if (f == 8 && c == 100) check(pcm_ready == 1'b0, "R7 pcm_ready mid-frame", 256'(pcm_ready), 0);
        if (f == 8 && c == 255) check(pcm_ready == 1'b1, "R7 pcm_ready at boundary", 256'(pcm_ready), 1);
        if ((f == 8 || f == 9) && c == 100) begin
          check(vol_ready == 1'b1, "R10 queue empty", 256'(vol_ready), 1);
          if (f == 8) offer_vol(7'h02, 16'h1F1F); else offer_vol(7'h18, 16'h0000);
          qv = 1; qi = vol_index; qd = vol_value;
        end
        if ((f == 8 || f == 9) && c == 101) vol_valid = 1'b0;
        if (f == 9 && c == 120) begin
          check(vol_ready == 1'b0, "R10 queue full blocks", 256'(vol_ready), 0);
          offer_vol(7'h02, 16'h8000);
        end
        if (f == 10 && c == 0) begin
          check(vol_ready == 1'b1, "R10 queue freed at boundary", 256'(vol_ready), 1);
          qv = 1; qi = vol_index; qd = vol_value;
        end
        if (c == 0) schedule(f);
        if (c == 255 && f < NFRAMES - 1) boundary();
      end
    end
  endtask

  task automatic monitor();
    logic [255:0] got, exp;
    string lbl;
    bit sync_ok;
    for (int f = 0; f < NFRAMES; f++) begin
      sync_ok = 1;
      for (int b = 0; b < 256; b++) begin
        if (f > 0 || b > 0) @(negedge clk);
        got[255 - b] = sdata_out;
        if (sync !== (b < 16)) sync_ok = 0;
      end
      check(sync_ok, $sformatf("R2 sync window frame %0d", f), 256'(sync_ok), 1);
      if (exp_q.size() == 0) begin
        check(0, "R1 no expected frame", got, '0);
      end else begin
        exp = exp_q.pop_front();
        lbl = lbl_q.pop_front();
        check(got === exp, $sformatf("%s frame %0d", lbl, f), got, exp);
      end
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(sync == 1'b1 && sdata_out == 1'b0, "R11 reset sync/data", {sync, sdata_out}, 2'b10);
    check(!pcm_ready && !vol_ready && !init_done, "R11 reset handshakes",
          {pcm_ready, vol_ready, init_done}, 0);
    rst = 1'b0;
    fork
      driver();
      monitor();
    join
    check(exp_q.size() == 0, "R1 leftover expected frames", 256'(exp_q.size()), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R1 got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule